// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block loads a configuration bitstream into a programmable logic device that listens in slave-serial mode. It toggles three lines of one 8-bit output port: an active-low reset, a configuration clock and a serial data line. A start request makes the engine pulse the device reset low for a set time. It then holds reset high for a settle interval before it accepts any data.

Bytes arrive on a valid/ready interface. Each accepted byte is shifted out least-significant bit first. The data line is set up while the clock is low, and the clock is then raised with the data held steady. The reset line stays high for the whole upload. An end-of-stream strobe, taken while the engine waits for a byte, ends the upload. The port then shows a fixed idle pattern in which only bit 4 is set, and the engine stays there until the next start request.

The intervals are set in microseconds and turned into clock cycles from a clock-frequency parameter. The length of each clock phase is set in cycles. The states are IDLE, RESET, SETTLE, WAIT, LOW, HIGH and DONE. The transitions are IDLE or DONE to RESET on start, RESET to SETTLE and SETTLE to WAIT when their timers expire, WAIT to LOW when a byte is accepted, WAIT to DONE on end of stream, LOW to HIGH when the phase expires, and HIGH back to LOW for the next bit or to WAIT after the eighth bit.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the engine is idle. `cfg_port` is 0x80 (reset line released, clock and data low), and `in_ready` and `cfg_done` are 0.
- R2: A start request in IDLE or DONE drives `cfg_port` to 0x00 for exactly RESET_US × (CLK_FREQ_HZ / 1e6) cycles.
- R3: After the reset pulse, `cfg_port` is 0x80 for exactly SETTLE_US × (CLK_FREQ_HZ / 1e6) cycles with `in_ready` low. After that, `in_ready` rises.
- R4: Bit 7 of `cfg_port` is the active-low device reset, bit 6 is the configuration clock and bit 5 is serial data. Bit 7 is high in every cycle in which bit 6 or bit 5 is high.
- R5: Each accepted byte produces exactly 8 clock rises. The data sampled at the rises follows the byte from bit 0 up to bit 7.
- R6: Data changes only while the clock is low and stays stable while the clock is high. Each high phase lasts exactly CCLK_PHASE cycles, and each low phase before a rise lasts at least CCLK_PHASE cycles.
- R7: `in_ready` is high only in WAIT, where `cfg_port` is 0x80. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge, and `in_ready` is low in the next cycle.
- R8: `stream_end` seen in WAIT, with `in_valid` low, moves the engine to DONE. There `cfg_port` is 0x10 and `cfg_done` is 1, and both hold until a start request.
- R9: When `in_valid` and `stream_end` are both high in WAIT, the byte is accepted and the stream is not ended.
- R10: A start request outside IDLE and DONE has no effect on the upload in progress.
- R11: A start request in DONE begins the full sequence again, with the output at 0x00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken in IDLE or DONE |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Byte to shift out |
| in_ready | output | 1 | Engine can accept a byte |
| stream_end | input | 1 | End of bitstream, taken in WAIT |
| cfg_port | output | 8 | Output port: bit 7 reset_n, bit 6 clock, bit 5 data, 0x10 when done |
| cfg_done | output | 1 | Engine is in DONE |

## Verification
The bench builds the engine with CLK_FREQ_HZ = 1,000,000, RESET_US = 4, SETTLE_US = 3 and CCLK_PHASE = 2. With these values each microsecond is one cycle, so the bench can count the reset and settle lengths cycle by cycle. A two-cycle phase lets it tell a held clock phase from a single-cycle toggle. The same values make byte streams, back-to-back bytes, a stray start request in the middle of a byte, the valid-versus-end collision and a second full configuration all short enough to run in one bench.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int PORT_W = 8;

    // Port bit positions; the attached device decodes these.
    localparam int PIN_NRST = 7;
    localparam int PIN_CCLK = 6;
    localparam int PIN_DIN  = 5;
    localparam logic [PORT_W-1:0] PAT_DONE = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_SETTLE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } scl_state_t;
endpackage

// File: rtl/scl_interval_timer.sv
module scl_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/scl_bit_shifter.sv
module scl_bit_shifter
    import scl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              advance,
    output logic              bit_out,
    output logic              last_bit
);
    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_byte;
            idx_q <= '0;
        end else if (advance) begin
            sh_q  <= {1'b0, sh_q[BYTE_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (idx_q == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int RESET_US    = 100,
    parameter int SETTLE_US   = 100,
    parameter int CCLK_PHASE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              stream_end,
    output logic [PORT_W-1:0] cfg_port,
    output logic              cfg_done
);
    localparam int CYC_PER_US_RAW = CLK_FREQ_HZ / 1_000_000;
    localparam int CYC_PER_US     = (CYC_PER_US_RAW < 1) ? 1 : CYC_PER_US_RAW;
    localparam int RST_CYC        = (RESET_US  < 1) ? CYC_PER_US : RESET_US  * CYC_PER_US;
    localparam int SET_CYC        = (SETTLE_US < 1) ? CYC_PER_US : SETTLE_US * CYC_PER_US;
    localparam int PH_CYC         = (CCLK_PHASE < 1) ? 1 : CCLK_PHASE;
    localparam int MAX_A          = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam int MAX_CYC        = (MAX_A > PH_CYC) ? MAX_A : PH_CYC;
    localparam int CNT_W          = $clog2(MAX_CYC + 1);

    scl_state_t       state_q, state_d;
    logic             t_load, t_exp;
    logic [CNT_W-1:0] t_val;
    logic             sh_load, sh_adv, sh_bit, sh_last;

    scl_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    scl_bit_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (in_data),
        .advance   (sh_adv),
        .bit_out   (sh_bit),
        .last_bit  (sh_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and timer/shifter control
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        sh_load = 1'b0;
        sh_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_RESET;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(RST_CYC - 1);
                end
            end
            ST_RESET: begin
                if (t_exp) begin
                    state_d = ST_SETTLE;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(SET_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (t_exp) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (in_valid) begin
                    state_d = ST_LOW;
                    sh_load = 1'b1;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(PH_CYC - 1);
                end else if (stream_end) begin
                    state_d = ST_DONE;
                end
            end
            ST_LOW: begin
                if (t_exp) begin
                    state_d = ST_HIGH;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(PH_CYC - 1);
                end
            end
            ST_HIGH: begin
                if (t_exp) begin
                    sh_adv = 1'b1;
                    if (sh_last) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_LOW;
                        t_load  = 1'b1;
                        t_val   = CNT_W'(PH_CYC - 1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cfg_port = '0;
        unique case (state_q)
            ST_IDLE, ST_SETTLE, ST_WAIT: cfg_port[PIN_NRST] = 1'b1;
            ST_RESET:                    cfg_port = '0;
            ST_LOW: begin
                cfg_port[PIN_NRST] = 1'b1;
                cfg_port[PIN_DIN]  = sh_bit;
            end
            ST_HIGH: begin
                cfg_port[PIN_NRST] = 1'b1;
                cfg_port[PIN_CCLK] = 1'b1;
                cfg_port[PIN_DIN]  = sh_bit;
            end
            ST_DONE:                     cfg_port = PAT_DONE;
            default:                     cfg_port = '0;
        endcase
    end

    assign in_ready = (state_q == ST_WAIT);
    assign cfg_done = (state_q == ST_DONE);
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] cfg_port,
    input logic       in_ready,
    input logic       cfg_done
);
    AST_NRST_HIGH_DURING_UPLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_port[6] || cfg_port[5]) |-> cfg_port[7]); // R4

    AST_DATA_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_port[6] && $past(cfg_port[6])) |-> (cfg_port[5] == $past(cfg_port[5]))); // R6

    AST_READY_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cfg_port == 8'h80)); // R7

    AST_DONE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (cfg_port == 8'h10)); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !start_i) |=> cfg_done); // R8

    AST_RESTART_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && start_i) |=> (cfg_port == 8'h00)); // R11
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_port (cfg_port),
    .in_ready (in_ready),
    .cfg_done (cfg_done)
);

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
    localparam int PH  = 2;
    localparam int RST = 4;
    localparam int SET = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       stream_end = 1'b0;
    logic [7:0] cfg_port;
    logic       cfg_done;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    serial_cfg_loader #(
        .CLK_FREQ_HZ (1_000_000),
        .RESET_US    (RST),
        .SETTLE_US   (SET),
        .CCLK_PHASE  (PH)
    ) u_serial_cfg_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .stream_end (stream_end),
        .cfg_port   (cfg_port),
        .cfg_done   (cfg_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bits at every clock rise on the port.
    logic [7:0] prev_port = 8'h80;
    int lo_len = 0;
    int hi_len = 0;
    bit rise_bit = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (cfg_port[6] && !prev_port[6]) begin
                chk(lo_len >= PH, "R6 low phase", lo_len, PH);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected clock rise", 1, 0);
                end else begin
                    rise_bit = exp_q.pop_front();
                    chk(cfg_port[5] == rise_bit, "R5 data bit", cfg_port[5], rise_bit);
                end
                chk(cfg_port[7], "R4 reset high at rise", cfg_port[7], 1);
                hi_len = 1;
                lo_len = 0;
            end else if (cfg_port[6]) begin
                hi_len++;
                if (cfg_port[5] != rise_bit) chk(1'b0, "R6 data moved while high", cfg_port[5], rise_bit);
            end else begin
                if (prev_port[6]) chk(hi_len == PH, "R6 high phase", hi_len, PH);
                lo_len++;
            end
            if (in_ready && cfg_port != 8'h80) chk(1'b0, "R7 ready outside wait", cfg_port, 8'h80);
            prev_port = cfg_port;
        end
    end

    task automatic wait_ready();
        do @(negedge clk); while (!in_ready);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit with_end);
        wait_ready();
        in_valid   = 1'b1;
        in_data    = b;
        stream_end = with_end;
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
        @(negedge clk);
        in_valid   = 1'b0;
        stream_end = 1'b0;
        chk(!in_ready, "R7 ready drops after accept", in_ready, 0);
        if (with_end) chk(!cfg_done, "R9 valid wins over end", cfg_done, 0);
    endtask

    task automatic run_start();
        int n;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (cfg_port == 8'h00 && n < 1000) begin n++; @(negedge clk); end
        chk(n == RST, "R2 reset pulse length", n, RST);
        n = 0;
        while (!in_ready && n < 1000) begin
            if (cfg_port != 8'h80) chk(1'b0, "R3 settle pattern", cfg_port, 8'h80);
            n++;
            @(negedge clk);
        end
        chk(n == SET, "R3 settle length", n, SET);
    endtask

    task automatic end_stream();
        wait_ready();
        stream_end = 1'b1;
        @(negedge clk);
        stream_end = 1'b0;
        chk(cfg_port == 8'h10, "R8 done pattern", cfg_port, 8'h10);
        chk(cfg_done, "R8 done flag", cfg_done, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cfg_port == 8'h80, "R1 idle port", cfg_port, 8'h80);
        chk(!in_ready, "R1 ready low", in_ready, 0);
        chk(!cfg_done, "R1 done low", cfg_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cfg_port == 8'h80, "R1 idle after release", cfg_port, 8'h80);
        mon_on = 1'b1;

        run_start();
        send_byte(8'hA5, 1'b0);
        send_byte(8'h01, 1'b0);
        // R10: stray start in the middle of a byte
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cfg_port[7], "R10 start ignored while busy", cfg_port[7], 1);
        send_byte(8'h80, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h00, 1'b0);
        send_byte(8'h5A, 1'b1);   // R9 collision
        send_byte(8'h3C, 1'b0);
        end_stream();
        chk(exp_q.size() == 0, "R5 all bits emitted", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        chk(cfg_port == 8'h10 && cfg_done, "R8 done holds", cfg_port, 8'h10);

        // R11: second configuration from DONE
        run_start();
        send_byte(8'hC3, 1'b0);
        end_stream();
        chk(exp_q.size() == 0, "R11 second load bits", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule